// File: doc/BRIEF.md
# Rotate-Zoom-Crop Source Address Generator

This block drives a bilinear image warp by inverse mapping. On a start pulse it walks every pixel of an output frame in raster order, one pixel per clock. For each output position it rotates the position about the centre of the output frame, scales the result by a zoom reciprocal and moves it to a crop origin in the input image. The result is a fixed-point source position. The block splits that position into an integer part and a fractional part. It emits the four neighbouring source coordinates, the row and column interpolation weights, the four linear memory addresses of those neighbours, and a flag for positions whose neighbourhood leaves the input image.

Sine and cosine of the angle come in as signed fixed-point numbers computed elsewhere. Their signs cover the whole turn from 0 to 360 degrees. The arithmetic runs through a four-register pipeline after the raster counter, so a downstream reader and a blender can consume one result every cycle. The transform inputs are captured when a frame starts. A new frame is accepted only after the pipeline has drained.

Top module: `rzc_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `out_valid`, `out_finish` and `busy` are low.
- R2: A start accepted while idle produces exactly OUT_W*OUT_H results on consecutive cycles, with no gap. They come in raster order: the column runs fastest, and row 0, column 0 comes first.
- R3: For output pixel (r, c), let dx = c - OUT_W/2 and dy = r - OUT_H/2. The rotated offsets are u = cos*dx + sin*dy and v = cos*dy - sin*dx. Sine and cosine are signed values with FRAC fractional bits, so 1.0 is 256 by default. Negative values are handled correctly.
- R4: Zoom is an unsigned reciprocal with FRAC fractional bits. The scaled offsets are (u*zoom)>>>FRAC and (v*zoom)>>>FRAC, both arithmetic shifts. A value of 256 leaves the offsets unchanged.
- R5: The source position in fixed point is sx = crop_col*2^FRAC + scaled u and sy = crop_row*2^FRAC + scaled v. `src_col0` is floor(sx / 2^FRAC) and `src_row0` is floor(sy / 2^FRAC).
- R6: `wt_col` holds the low FRAC bits of sx and `wt_row` the low FRAC bits of sy. These are the non-negative fractional distances beyond col0 and row0.
- R7: `src_col1` = col0+1 and `src_row1` = row0+1. The addresses are row*IN_W+col: top-left uses (row0, col0), top-right (row0, col1), bottom-left (row1, col0) and bottom-right (row1, col1). All four addresses are 0 when the pixel is out of range.
- R8: `out_oor` is high exactly when col0 < 0, col0 > IN_W-2, row0 < 0 or row0 > IN_H-2, that is, when any of the four neighbours falls outside the input image.
- R9: `out_finish` is high together with `out_valid` on the last pixel of the frame only.
- R10: `busy` is high from the cycle after an accepted start until the last result has left the block. A start while busy is ignored, and changes to the transform inputs during a frame have no effect on that frame.
- R11: The first `out_valid` appears on the fourth rising edge after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; taken only when idle |
| sin_in | input | TRIG_W | Signed sine, FRAC fractional bits |
| cos_in | input | TRIG_W | Signed cosine, FRAC fractional bits |
| zoom_in | input | ZOOM_W | Unsigned zoom reciprocal, FRAC fractional bits |
| crop_col | input | clog2(IN_W) | Crop origin column in the input image |
| crop_row | input | clog2(IN_H) | Crop origin row in the input image |
| busy | output | 1 | Frame in progress or pipeline not empty |
| out_valid | output | 1 | Result fields are valid this cycle |
| out_finish | output | 1 | Last pixel of the frame |
| out_oor | output | 1 | Neighbourhood outside the input image |
| src_col0 | output | COORD_W | Signed left neighbour column |
| src_col1 | output | COORD_W | Signed right neighbour column |
| src_row0 | output | COORD_W | Signed top neighbour row |
| src_row1 | output | COORD_W | Signed bottom neighbour row |
| wt_col | output | FRAC | Column interpolation weight |
| wt_row | output | FRAC | Row interpolation weight |
| addr_tl | output | clog2(IN_W*IN_H) | Top-left linear address |
| addr_tr | output | clog2(IN_W*IN_H) | Top-right linear address |
| addr_bl | output | clog2(IN_W*IN_H) | Bottom-left linear address |
| addr_br | output | clog2(IN_W*IN_H) | Bottom-right linear address |

## Verification
The bench runs four frames: identity, a quarter turn with 2x magnification, a shallow angle whose corners map to negative positions, and an angle in the third quadrant that pushes past the right and bottom edges. A design that truncated toward zero instead of taking the floor would report a column one too high, with a mirrored weight, for negative positions. A design with a swapped sine sign would rotate the wrong way. A bounds test off by one would either allow reads at column IN_W or reject the last valid column. In the third frame a second start arrives mid-frame while the transform inputs change; a design that re-captured them or restarted the counter would emit mismatching or surplus results. The frame length and the start-to-first-result latency are counted, which catches a dropped pipeline stage or a valid chain with a gap.

// File: rtl/rzc_pkg.sv
package rzc_pkg;
  localparam int ACC_W = 32;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef struct packed {
    acc_t sin_v;
    acc_t cos_v;
    acc_t zoom_v;
    acc_t crop_x;
    acc_t crop_y;
  } xform_t;
endpackage

// File: rtl/rzc_raster_scan.sv
module rzc_raster_scan
  import rzc_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int OUT_H  = 12,
  parameter int TRIG_W = 10,
  parameter int ZOOM_W = 12,
  parameter int CXW    = 5,
  parameter int CYW    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     pipe_busy,
  input  logic signed [TRIG_W-1:0] sin_i,
  input  logic signed [TRIG_W-1:0] cos_i,
  input  logic [ZOOM_W-1:0]        zoom_i,
  input  logic [CXW-1:0]           crop_x_i,
  input  logic [CYW-1:0]           crop_y_i,
  output logic                     active_o,
  output logic                     last_o,
  output acc_t                     dx_o,
  output acc_t                     dy_o,
  output acc_t                     sin_o,
  output acc_t                     cos_o,
  output acc_t                     zoom_o,
  output acc_t                     crop_x_o,
  output acc_t                     crop_y_o
);
  localparam int CW = (OUT_W > 1) ? $clog2(OUT_W) : 1;
  localparam int RW = (OUT_H > 1) ? $clog2(OUT_H) : 1;
  localparam logic [CW-1:0] LAST_COL = CW'(OUT_W - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(OUT_H - 1);
  localparam int HALF_W = OUT_W / 2;
  localparam int HALF_H = OUT_H / 2;

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          active_q;
  xform_t        xf_q;
  logic          accept;
  logic          end_col;
  logic          end_row;

  assign accept  = start && !active_q && !pipe_busy;
  assign end_col = (col_q == LAST_COL);
  assign end_row = (row_q == LAST_ROW);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
      xf_q     <= '0;
    end else if (accept) begin
      active_q    <= 1'b1;
      col_q       <= '0;
      row_q       <= '0;
      xf_q.sin_v  <= acc_t'(sin_i);
      xf_q.cos_v  <= acc_t'(cos_i);
      xf_q.zoom_v <= acc_t'(zoom_i);
      xf_q.crop_x <= acc_t'(crop_x_i);
      xf_q.crop_y <= acc_t'(crop_y_i);
    end else if (active_q) begin
      if (end_col) begin
        col_q <= '0;
        if (end_row) active_q <= 1'b0;
        else         row_q <= row_q + RW'(1);
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q && end_col && end_row;
  assign dx_o     = acc_t'(col_q) - acc_t'(HALF_W);
  assign dy_o     = acc_t'(row_q) - acc_t'(HALF_H);
  assign sin_o    = xf_q.sin_v;
  assign cos_o    = xf_q.cos_v;
  assign zoom_o   = xf_q.zoom_v;
  assign crop_x_o = xf_q.crop_x;
  assign crop_y_o = xf_q.crop_y;

  AST_PARAMS_HELD: assert property (@(posedge clk) disable iff (rst)
    (active_q && start) |=> $stable(xf_q)); // R10

  AST_RASTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    (active_q && end_col && !end_row) |=>
      (active_q && col_q == '0 && row_q == ($past(row_q) + RW'(1)))); // R2
endmodule

// File: rtl/rzc_rotate.sv
module rzc_rotate
  import rzc_pkg::*;
#(
  parameter int FRAC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic last_i,
  input  acc_t dx_i,
  input  acc_t dy_i,
  input  acc_t sin_i,
  input  acc_t cos_i,
  output logic valid_o,
  output logic last_o,
  output logic busy_o,
  output acc_t u_o,
  output acc_t v_o
);
  localparam acc_t ONE = acc_t'(1) <<< FRAC;

  logic v1_q, l1_q, v2_q, l2_q;
  acc_t p_cx_q, p_sy_q, p_sx_q, p_cy_q;
  acc_t u_q, v_q;

  // stage 1: the four products
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      l1_q <= 1'b0;
    end else begin
      v1_q <= valid_i;
      l1_q <= last_i && valid_i;
    end
    p_cx_q <= cos_i * dx_i;
    p_sy_q <= sin_i * dy_i;
    p_sx_q <= sin_i * dx_i;
    p_cy_q <= cos_i * dy_i;
  end

  // stage 2: combine into rotated offsets
  always_ff @(posedge clk) begin
    if (rst) begin
      v2_q <= 1'b0;
      l2_q <= 1'b0;
    end else begin
      v2_q <= v1_q;
      l2_q <= l1_q;
    end
    u_q <= p_cx_q + p_sy_q;
    v_q <= p_cy_q - p_sx_q;
  end

  assign valid_o = v2_q;
  assign last_o  = l2_q;
  assign busy_o  = v1_q || v2_q;
  assign u_o     = u_q;
  assign v_o     = v_q;

  AST_ANGLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (v2_q && sin_i == '0 && cos_i == ONE) |->
      (u_q == ($past(dx_i, 2) <<< FRAC) && v_q == ($past(dy_i, 2) <<< FRAC))); // R3
endmodule

// File: rtl/rzc_scale_offset.sv
module rzc_scale_offset
  import rzc_pkg::*;
#(
  parameter int FRAC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic last_i,
  input  acc_t u_i,
  input  acc_t v_i,
  input  acc_t zoom_i,
  input  acc_t crop_x_i,
  input  acc_t crop_y_i,
  output logic valid_o,
  output logic last_o,
  output acc_t sx_o,
  output acc_t sy_o
);
  localparam acc_t ONE = acc_t'(1) <<< FRAC;

  acc_t prod_u, prod_v;
  logic v_q, l_q;
  acc_t sx_q, sy_q;

  always_comb begin
    prod_u = u_i * zoom_i;
    prod_v = v_i * zoom_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      l_q <= 1'b0;
    end else begin
      v_q <= valid_i;
      l_q <= last_i && valid_i;
    end
    sx_q <= (crop_x_i <<< FRAC) + (prod_u >>> FRAC);
    sy_q <= (crop_y_i <<< FRAC) + (prod_v >>> FRAC);
  end

  assign valid_o = v_q;
  assign last_o  = l_q;
  assign sx_o    = sx_q;
  assign sy_o    = sy_q;

  AST_UNIT_ZOOM: assert property (@(posedge clk) disable iff (rst)
    (v_q && zoom_i == ONE) |->
      (sx_q == $past(u_i) + (crop_x_i <<< FRAC) &&
       sy_q == $past(v_i) + (crop_y_i <<< FRAC))); // R4
endmodule

// File: rtl/rzc_addr_flatten.sv
module rzc_addr_flatten
  import rzc_pkg::*;
#(
  parameter int FRAC    = 8,
  parameter int IN_W    = 32,
  parameter int IN_H    = 24,
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid_i,
  input  logic                      last_i,
  input  acc_t                      sx_i,
  input  acc_t                      sy_i,
  output logic                      valid_o,
  output logic                      finish_o,
  output logic                      oor_o,
  output logic signed [COORD_W-1:0] col0_o,
  output logic signed [COORD_W-1:0] col1_o,
  output logic signed [COORD_W-1:0] row0_o,
  output logic signed [COORD_W-1:0] row1_o,
  output logic [FRAC-1:0]           wt_col_o,
  output logic [FRAC-1:0]           wt_row_o,
  output logic [ADDR_W-1:0]         addr_tl_o,
  output logic [ADDR_W-1:0]         addr_tr_o,
  output logic [ADDR_W-1:0]         addr_bl_o,
  output logic [ADDR_W-1:0]         addr_br_o
);
  localparam acc_t WIDTH  = acc_t'(IN_W);
  localparam acc_t MAX_X0 = acc_t'(IN_W - 2);
  localparam acc_t MAX_Y0 = acc_t'(IN_H - 2);

  acc_t x0_c, x1_c, y0_c, y1_c;
  logic oor_c;

  always_comb begin
    x0_c  = sx_i >>> FRAC;
    y0_c  = sy_i >>> FRAC;
    x1_c  = x0_c + acc_t'(1);
    y1_c  = y0_c + acc_t'(1);
    oor_c = (x0_c < 0) || (x0_c > MAX_X0) || (y0_c < 0) || (y0_c > MAX_Y0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      finish_o <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      finish_o <= last_i && valid_i;
    end
    oor_o    <= oor_c;
    col0_o   <= COORD_W'(x0_c);
    col1_o   <= COORD_W'(x1_c);
    row0_o   <= COORD_W'(y0_c);
    row1_o   <= COORD_W'(y1_c);
    wt_col_o <= sx_i[FRAC-1:0];
    wt_row_o <= sy_i[FRAC-1:0];
    if (oor_c) begin
      addr_tl_o <= '0;
      addr_tr_o <= '0;
      addr_bl_o <= '0;
      addr_br_o <= '0;
    end else begin
      addr_tl_o <= ADDR_W'(y0_c * WIDTH + x0_c);
      addr_tr_o <= ADDR_W'(y0_c * WIDTH + x1_c);
      addr_bl_o <= ADDR_W'(y1_c * WIDTH + x0_c);
      addr_br_o <= ADDR_W'(y1_c * WIDTH + x1_c);
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && !finish_o)); // R1

  AST_FINISH_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    finish_o |-> valid_o); // R9

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !oor_o) |->
      (col0_o >= 0 && row0_o >= 0 &&
       col1_o <= COORD_W'(IN_W - 1) && row1_o <= COORD_W'(IN_H - 1))); // R8

  AST_NEIGHBOUR_ADDR: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !oor_o) |->
      (addr_tr_o == addr_tl_o + ADDR_W'(1) &&
       addr_bl_o == addr_tl_o + ADDR_W'(IN_W) &&
       addr_br_o == addr_bl_o + ADDR_W'(1))); // R7
endmodule

// File: rtl/rzc_addr_gen.sv
module rzc_addr_gen
  import rzc_pkg::*;
#(
  parameter int OUT_W   = 16,
  parameter int OUT_H   = 12,
  parameter int IN_W    = 32,
  parameter int IN_H    = 24,
  parameter int FRAC    = 8,
  parameter int TRIG_W  = 10,
  parameter int ZOOM_W  = 12,
  parameter int COORD_W = 12,
  localparam int CXW    = $clog2(IN_W),
  localparam int CYW    = $clog2(IN_H),
  localparam int ADDR_W = $clog2(IN_W * IN_H)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic signed [TRIG_W-1:0]  sin_in,
  input  logic signed [TRIG_W-1:0]  cos_in,
  input  logic [ZOOM_W-1:0]         zoom_in,
  input  logic [CXW-1:0]            crop_col,
  input  logic [CYW-1:0]            crop_row,
  output logic                      busy,
  output logic                      out_valid,
  output logic                      out_finish,
  output logic                      out_oor,
  output logic signed [COORD_W-1:0] src_col0,
  output logic signed [COORD_W-1:0] src_col1,
  output logic signed [COORD_W-1:0] src_row0,
  output logic signed [COORD_W-1:0] src_row1,
  output logic [FRAC-1:0]           wt_col,
  output logic [FRAC-1:0]           wt_row,
  output logic [ADDR_W-1:0]         addr_tl,
  output logic [ADDR_W-1:0]         addr_tr,
  output logic [ADDR_W-1:0]         addr_bl,
  output logic [ADDR_W-1:0]         addr_br
);
  logic scan_active, scan_last;
  acc_t dx, dy, sin_l, cos_l, zoom_l, cx_l, cy_l;
  logic rot_valid, rot_last, rot_busy;
  acc_t u, v;
  logic sc_valid, sc_last;
  acc_t sx, sy;
  logic pipe_busy;

  assign pipe_busy = rot_busy || sc_valid || out_valid;
  assign busy      = scan_active || pipe_busy;

  rzc_raster_scan #(
    .OUT_W(OUT_W), .OUT_H(OUT_H), .TRIG_W(TRIG_W), .ZOOM_W(ZOOM_W),
    .CXW(CXW), .CYW(CYW)
  ) u_scan (
    .clk(clk), .rst(rst), .start(start), .pipe_busy(pipe_busy),
    .sin_i(sin_in), .cos_i(cos_in), .zoom_i(zoom_in),
    .crop_x_i(crop_col), .crop_y_i(crop_row),
    .active_o(scan_active), .last_o(scan_last), .dx_o(dx), .dy_o(dy),
    .sin_o(sin_l), .cos_o(cos_l), .zoom_o(zoom_l),
    .crop_x_o(cx_l), .crop_y_o(cy_l)
  );

  rzc_rotate #(.FRAC(FRAC)) u_rot (
    .clk(clk), .rst(rst), .valid_i(scan_active), .last_i(scan_last),
    .dx_i(dx), .dy_i(dy), .sin_i(sin_l), .cos_i(cos_l),
    .valid_o(rot_valid), .last_o(rot_last), .busy_o(rot_busy),
    .u_o(u), .v_o(v)
  );

  rzc_scale_offset #(.FRAC(FRAC)) u_scale (
    .clk(clk), .rst(rst), .valid_i(rot_valid), .last_i(rot_last),
    .u_i(u), .v_i(v), .zoom_i(zoom_l), .crop_x_i(cx_l), .crop_y_i(cy_l),
    .valid_o(sc_valid), .last_o(sc_last), .sx_o(sx), .sy_o(sy)
  );

  rzc_addr_flatten #(
    .FRAC(FRAC), .IN_W(IN_W), .IN_H(IN_H), .COORD_W(COORD_W), .ADDR_W(ADDR_W)
  ) u_flat (
    .clk(clk), .rst(rst), .valid_i(sc_valid), .last_i(sc_last),
    .sx_i(sx), .sy_i(sy),
    .valid_o(out_valid), .finish_o(out_finish), .oor_o(out_oor),
    .col0_o(src_col0), .col1_o(src_col1), .row0_o(src_row0), .row1_o(src_row1),
    .wt_col_o(wt_col), .wt_row_o(wt_row),
    .addr_tl_o(addr_tl), .addr_tr_o(addr_tr), .addr_bl_o(addr_bl), .addr_br_o(addr_br)
  );

  AST_START_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> scan_active); // R11
endmodule

// File: tb/rzc_addr_gen_bench.sv
`timescale 1ns/1ps
module rzc_addr_gen_bench;
  localparam int OUT_W = 16, OUT_H = 12, IN_W = 32, IN_H = 24;
  localparam int FRAC = 8, TRIG_W = 10, ZOOM_W = 12, COORD_W = 12;
  localparam int NPIX = OUT_W * OUT_H;
  localparam int ADDR_W = $clog2(IN_W * IN_H);
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [TRIG_W-1:0] sin_in = '0;
  logic signed [TRIG_W-1:0] cos_in = '0;
  logic [ZOOM_W-1:0] zoom_in = '0;
  logic [$clog2(IN_W)-1:0] crop_col = '0;
  logic [$clog2(IN_H)-1:0] crop_row = '0;
  logic busy, out_valid, out_finish, out_oor;
  logic signed [COORD_W-1:0] src_col0, src_col1, src_row0, src_row1;
  logic [FRAC-1:0] wt_col, wt_row;
  logic [ADDR_W-1:0] addr_tl, addr_tr, addr_bl, addr_br;

  rzc_addr_gen #(
    .OUT_W(OUT_W), .OUT_H(OUT_H), .IN_W(IN_W), .IN_H(IN_H), .FRAC(FRAC),
    .TRIG_W(TRIG_W), .ZOOM_W(ZOOM_W), .COORD_W(COORD_W)
  ) u_rzc_addr_gen (
    .clk(clk), .rst(rst), .start(start), .sin_in(sin_in), .cos_in(cos_in),
    .zoom_in(zoom_in), .crop_col(crop_col), .crop_row(crop_row), .busy(busy),
    .out_valid(out_valid), .out_finish(out_finish), .out_oor(out_oor),
    .src_col0(src_col0), .src_col1(src_col1), .src_row0(src_row0), .src_row1(src_row1),
    .wt_col(wt_col), .wt_row(wt_row),
    .addr_tl(addr_tl), .addr_tr(addr_tr), .addr_bl(addr_bl), .addr_br(addr_br)
  );

  always #2 clk = ~clk;

  typedef struct {
    int x0, y0, fx, fy, oor, tl, tr, bl, br;
  } exp_t;

  exp_t expq[$];
  exp_t me;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R3";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model of one frame, pixels pushed in raster order
  task automatic model_frame(input int s, input int c, input int z, input int cx, input int cy);
    for (int r = 0; r < OUT_H; r++) begin
      for (int k = 0; k < OUT_W; k++) begin
        exp_t e;
        int dx, dy, u, v, sx, sy;
        dx = k - OUT_W / 2;
        dy = r - OUT_H / 2;
        u  = c * dx + s * dy;
        v  = c * dy - s * dx;
        sx = cx * 256 + ((u * z) >>> FRAC);
        sy = cy * 256 + ((v * z) >>> FRAC);
        e.x0 = sx >>> FRAC;
        e.y0 = sy >>> FRAC;
        e.fx = sx & 255;
        e.fy = sy & 255;
        e.oor = (e.x0 < 0 || e.x0 > IN_W - 2 || e.y0 < 0 || e.y0 > IN_H - 2) ? 1 : 0;
        e.tl = e.oor ? 0 : e.y0 * IN_W + e.x0;
        e.tr = e.oor ? 0 : e.y0 * IN_W + e.x0 + 1;
        e.bl = e.oor ? 0 : (e.y0 + 1) * IN_W + e.x0;
        e.br = e.oor ? 0 : (e.y0 + 1) * IN_W + e.x0 + 1;
        expq.push_back(e);
      end
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (out_finish && !out_valid) chk(1'b0, "R9 finish without valid", 1, 0);
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R10 unexpected extra result", 1, 0);
        end else begin
          chk(out_finish == (expq.size() == 1), "R9 finish flag", int'(out_finish), int'(expq.size() == 1));
          me = expq.pop_front();
          chk(int'(src_col0) == me.x0, {cur_tag, " R5 col0"}, int'(src_col0), me.x0);
          chk(int'(src_row0) == me.y0, {cur_tag, " R5 row0"}, int'(src_row0), me.y0);
          chk(int'(src_col1) == me.x0 + 1, "R7 col1", int'(src_col1), me.x0 + 1);
          chk(int'(src_row1) == me.y0 + 1, "R7 row1", int'(src_row1), me.y0 + 1);
          chk(int'(wt_col) == me.fx, "R6 col weight", int'(wt_col), me.fx);
          chk(int'(wt_row) == me.fy, "R6 row weight", int'(wt_row), me.fy);
          chk(int'(out_oor) == me.oor, "R8 out of range", int'(out_oor), me.oor);
          chk(int'(addr_tl) == me.tl, "R7 addr tl", int'(addr_tl), me.tl);
          chk(int'(addr_tr) == me.tr, "R7 addr tr", int'(addr_tr), me.tr);
          chk(int'(addr_bl) == me.bl, "R7 addr bl", int'(addr_bl), me.bl);
          chk(int'(addr_br) == me.br, "R7 addr br", int'(addr_br), me.br);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_frame(input string tag, input int s, input int c, input int z,
                           input int cx, input int cy, input bit poke);
    int k;
    int n;
    cur_tag = tag;
    model_frame(s, c, z, cx, cy);
    @(negedge clk);
    sin_in = TRIG_W'(s);
    cos_in = TRIG_W'(c);
    zoom_in = ZOOM_W'(z);
    crop_col = $bits(crop_col)'(cx);
    crop_row = $bits(crop_row)'(cy);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    k = 1;
    while (!out_valid && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk(k == 5, "R11 first result latency", k, 5);
    n = 0;
    while (out_valid && !out_finish && n < NPIX + 5) begin
      n++;
      if (poke && n == 20) begin
        start = 1'b1;
        sin_in = 10'sd77;
        cos_in = -10'sd200;
        zoom_in = 12'd900;
        crop_col = 5'd3;
        crop_row = 5'd20;
      end else if (poke && n == 21) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    if (out_valid && out_finish) n++;
    chk(n == NPIX, "R2 contiguous frame length", n, NPIX);
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, "R2 all results delivered", expq.size(), 0);
    chk(busy == 1'b0, "R10 idle after frame", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_finish && !busy, "R1 quiet during reset",
        int'({out_valid, out_finish, busy}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !out_finish && !busy, "R1 quiet after reset",
        int'({out_valid, out_finish, busy}), 0);
    // R3 identity angle, unit zoom, interior crop
    run_frame("R3", 0, 256, 256, 10, 8, 1'b0);
    // R4 quarter turn with 2x magnification, half-pixel weights
    run_frame("R4", 256, 0, 128, 15, 11, 1'b0);
    // R3 shallow angle, minification, negative corners, mid-frame start (R10)
    run_frame("R3", 128, 222, 384, 4, 4, 1'b1);
    // R3 third-quadrant angle pushing past right and bottom edges
    run_frame("R3", -128, -222, 200, 30, 22, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule